// File: doc/BRIEF.md
# Page-Mode DRAM Line Fill Controller

This block moves whole 32-byte cache lines between a 128-bit write-back cache and a 64-bit DRAM array. A cache miss becomes a line read and a dirty victim becomes a line write. Each line takes one row activation followed by four page-mode column accesses. The block drives the row and column strobes, the write enable and the multiplexed row/column address. On reads it packs pairs of 64-bit beats into 128-bit cache words. On writes it unpacks the latched victim line into beats.

Every 32-bit longword carries one parity bit. The block moves that bit along with its longword in both directions and never generates or checks it. Every DRAM-facing signal comes from a flip-flop in the single system clock domain. Timing is set by fixed cycle counts: row-to-column delay, column strobe low time and row precharge. Refresh, tag lookup and parity checking belong to neighbouring blocks.

A requester raises `reqValid` with the line address and, for a write, the victim line and its parity. It receives a one-cycle `reqAck` when the block takes the request and a one-cycle `done` when the row has closed.

Top module: `line_fill_ctrl`

## Requirements
- R1: While `rstN` is low, `dramRasN`, `dramCasN` and `dramWeN` are 1, and `dramDqOe`, `reqAck`, `done` and `fillValid` are 0. A reset in the middle of a transfer returns the strobes high.
- R2: A request is taken only when the block is idle. `reqAck` is high for exactly one cycle, in the first cycle that `dramRasN` is low. `reqValid` seen while a transfer is in progress is ignored: there is no acknowledge and no DRAM activity for it.
- R3: When `dramRasN` falls, `dramAddr` carries the row, which is `reqLine[15:7]`. `dramCasN` first falls exactly 2 cycles after `dramRasN` falls. `dramAddr` holds steady while `dramCasN` is low.
- R4: Each transfer makes exactly four column strobes under one row strobe. Each strobe is low for exactly 2 cycles, with exactly 1 high cycle between strobes. The column for beat b is `{reqLine[6:0], b}`, and b runs 0, 1, 2, 3 in that order.
- R5: On a read, cache word 0 is `{beat1, beat0}` and cache word 1 is `{beat3, beat2}`, with the lower beat in bits [63:0]. Each word appears with a one-cycle `fillValid`, and `fillIdx` gives the word number.
- R6: Parity bit i of a beat (`dramParIn`/`dramParOut`) belongs to bits [32i+31:32i] of that beat. Parity bit j of a cache word (`fillPar`, and `wbPar` for word w at `wbPar[4w+3:4w]`) belongs to bits [32j+31:32j] of that word. Parity values are copied unchanged, including values that do not match the data.
- R7: On a write, beat b carries `wbLine[64b+63:64b]` and parity `wbPar[2b+1:2b]`, as latched at acknowledge. `dramWeN` is low and `dramDqOe` is high for the whole of each column strobe. On reads `dramWeN` stays high.
- R8: `done` is high for exactly one cycle: the first cycle with `dramRasN` high after the fourth beat. On a read, the `fillValid` for cache word 1 falls in this same cycle.
- R9: Between transfers `dramRasN` stays high for at least 3 cycles: 2 of precharge plus 1 idle accept cycle. A request held high is acknowledged again exactly 16 cycles after the previous acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request |
| reqWrite | input | 1 | 1 = write back victim line, 0 = read fill |
| reqLine | input | 16 | Line address: row in [15:7], column high bits in [6:0] |
| wbLine | input | 256 | Victim line, cache word 0 in [127:0] |
| wbPar | input | 8 | Victim longword parity, one bit per longword |
| reqAck | output | 1 | One-cycle request acknowledge |
| done | output | 1 | One-cycle transfer completion |
| fillValid | output | 1 | Fill word valid |
| fillIdx | output | 1 | Fill word number within the line |
| fillWord | output | 128 | Packed fill word |
| fillPar | output | 4 | Parity of the fill word, one bit per longword |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramAddr | output | 9 | Multiplexed row/column address |
| dramDqOut | output | 64 | Write data to the DRAM |
| dramParOut | output | 2 | Write parity to the DRAM |
| dramDqOe | output | 1 | Write data drive enable |
| dramDqIn | input | 64 | Read data from the DRAM |
| dramParIn | input | 2 | Read parity from the DRAM |

## Verification
On a read, the capture of the fourth beat completes cache word 1 on the same clock edge that closes the row and raises `done`. A read fill therefore always puts the last `fillValid` and `done` in one cycle. Every read transfer provokes this, including back-to-back reads made by holding `reqValid` high. The bench judges it by recording, whenever `fillValid` with `fillIdx` of 1 is seen, whether `done` is high in that same sample. It also separately checks that `done` appears only once the row strobe has risen.

// File: rtl/lf_pkg.sv
package lf_pkg;

  localparam int LINE_BEATS = 4;
  localparam int LW_BITS    = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_CPRE,
    ST_RP
  } lfState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latch;     // take victim line at accept
    logic       drive;     // load beat onto DRAM data, enable output
    logic       dqRelease; // stop driving DRAM data
    logic       capture;   // sample DRAM read data
    logic [1:0] beat;      // beat number for drive/capture
  } lfStrobe_t;

endpackage

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 9,
  parameter int TRCD   = 2,
  parameter int TCAS   = 2,
  parameter int TRP    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ROW_W+COL_W-3:0]   reqLine,
  output logic                     reqAck,
  output logic                     done,
  output logic                     rasN,
  output logic                     casN,
  output logic                     weN,
  output logic [ADDR_W-1:0]        dramAddr,
  output lfStrobe_t                strobe
);

  localparam int COLHI_W = COL_W - 2;
  localparam int MAXT    = (TRCD > TCAS) ? ((TRCD > TRP) ? TRCD : TRP)
                                         : ((TCAS > TRP) ? TCAS : TRP);
  localparam int CNT_W   = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(TCAS - 1);
  localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(TRP - 1);

  lfState_t           state;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         beat;
  logic               isWrite;
  logic [COLHI_W-1:0] colHiQ;

  function automatic logic [ADDR_W-1:0] colAddr(input logic [COLHI_W-1:0] hi,
                                                input logic [1:0] b);
    return ADDR_W'({hi, b});
  endfunction

  // strobes toward the datapath, aligned with the edge that moves the DRAM pins
  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: strobe.latch = reqValid;
      ST_RCD: begin
        if (cnt == RCD_LAST) begin
          strobe.drive = isWrite;
          strobe.beat  = 2'd0;
        end
      end
      ST_CAS: begin
        if (cnt == CAS_LAST) begin
          strobe.capture   = !isWrite;
          strobe.dqRelease = isWrite;
          strobe.beat      = beat;
        end
      end
      ST_CPRE: begin
        strobe.drive = isWrite;
        strobe.beat  = beat + 2'd1;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      beat     <= '0;
      isWrite  <= 1'b0;
      colHiQ   <= '0;
      rasN     <= 1'b1;
      casN     <= 1'b1;
      weN      <= 1'b1;
      dramAddr <= '0;
      reqAck   <= 1'b0;
      done     <= 1'b0;
    end else begin
      reqAck <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isWrite  <= reqWrite;
            colHiQ   <= reqLine[COLHI_W-1:0];
            dramAddr <= ADDR_W'(reqLine[ROW_W+COLHI_W-1:COLHI_W]);
            rasN     <= 1'b0;
            reqAck   <= 1'b1;
            beat     <= '0;
            cnt      <= '0;
            state    <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (cnt == RCD_LAST) begin
            casN     <= 1'b0;
            weN      <= !isWrite;
            dramAddr <= colAddr(colHiQ, 2'd0);
            cnt      <= '0;
            state    <= ST_CAS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAS: begin
          if (cnt == CAS_LAST) begin
            casN <= 1'b1;
            weN  <= 1'b1;
            cnt  <= '0;
            if (beat == 2'd3) begin
              rasN  <= 1'b1;
              done  <= 1'b1;
              state <= ST_RP;
            end else begin
              state <= ST_CPRE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CPRE: begin
          casN     <= 1'b0;
          weN      <= !isWrite;
          beat     <= beat + 2'd1;
          dramAddr <= colAddr(colHiQ, beat + 2'd1);
          state    <= ST_CAS;
        end
        ST_RP: begin
          if (cnt == RP_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R8
  done_row_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rasN && casN));

  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !$past(casN)) |-> $stable(weN));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !$past(casN)) |-> $stable(dramAddr));

endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int MEM_W = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  lfStrobe_t                          strobe,
  input  logic [LINE_BEATS*MEM_W-1:0]        wbLine,
  input  logic [LINE_BEATS*MEM_W/LW_BITS-1:0] wbPar,
  input  logic [MEM_W-1:0]                   dramDqIn,
  input  logic [MEM_W/LW_BITS-1:0]           dramParIn,
  output logic                               fillValid,
  output logic                               fillIdx,
  output logic [2*MEM_W-1:0]                 fillWord,
  output logic [2*MEM_W/LW_BITS-1:0]         fillPar,
  output logic [MEM_W-1:0]                   dqOut,
  output logic [MEM_W/LW_BITS-1:0]           parOut,
  output logic                               dqOe
);

  localparam int PAR_W  = MEM_W / LW_BITS;
  localparam int LINE_W = LINE_BEATS * MEM_W;
  localparam int LPAR_W = LINE_BEATS * PAR_W;

  logic [LINE_W-1:0] wbLineQ;
  logic [LPAR_W-1:0] wbParQ;
  logic [MEM_W-1:0]  wbLane  [LINE_BEATS];
  logic [PAR_W-1:0]  parLane [LINE_BEATS];
  logic [MEM_W-1:0]  lowBeat;
  logic [PAR_W-1:0]  lowPar;

  // split the latched victim line into beat lanes, parity kept with its lane
  for (genvar g = 0; g < LINE_BEATS; g++) begin : g_lane
    assign wbLane[g]  = wbLineQ[g*MEM_W +: MEM_W];
    assign parLane[g] = wbParQ[g*PAR_W +: PAR_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbLineQ   <= '0;
      wbParQ    <= '0;
      dqOut     <= '0;
      parOut    <= '0;
      dqOe      <= 1'b0;
      lowBeat   <= '0;
      lowPar    <= '0;
      fillValid <= 1'b0;
      fillIdx   <= 1'b0;
      fillWord  <= '0;
      fillPar   <= '0;
    end else begin
      fillValid <= 1'b0;
      if (strobe.latch) begin
        wbLineQ <= wbLine;
        wbParQ  <= wbPar;
      end
      if (strobe.drive) begin
        dqOut  <= wbLane[strobe.beat];
        parOut <= parLane[strobe.beat];
        dqOe   <= 1'b1;
      end else if (strobe.dqRelease) begin
        dqOe <= 1'b0;
      end
      if (strobe.capture) begin
        if (!strobe.beat[0]) begin
          lowBeat <= dramDqIn;
          lowPar  <= dramParIn;
        end else begin
          fillWord  <= {dramDqIn, lowBeat};
          fillPar   <= {dramParIn, lowPar};
          fillIdx   <= strobe.beat[1];
          fillValid <= 1'b1;
        end
      end
    end
  end

  // R7
  oe_fill_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !fillValid);

  // R5
  fill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !fillValid);

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl
  import lf_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int MEM_W = 64,
  parameter int TRCD  = 2,
  parameter int TCAS  = 2,
  parameter int TRP   = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic                                  reqWrite,
  input  logic [ROW_W+COL_W-3:0]                reqLine,
  input  logic [LINE_BEATS*MEM_W-1:0]           wbLine,
  input  logic [LINE_BEATS*MEM_W/LW_BITS-1:0]   wbPar,
  output logic                                  reqAck,
  output logic                                  done,
  output logic                                  fillValid,
  output logic                                  fillIdx,
  output logic [2*MEM_W-1:0]                    fillWord,
  output logic [2*MEM_W/LW_BITS-1:0]            fillPar,
  output logic                                  dramRasN,
  output logic                                  dramCasN,
  output logic                                  dramWeN,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [MEM_W-1:0]                      dramDqOut,
  output logic [MEM_W/LW_BITS-1:0]              dramParOut,
  output logic                                  dramDqOe,
  input  logic [MEM_W-1:0]                      dramDqIn,
  input  logic [MEM_W/LW_BITS-1:0]              dramParIn
);

  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  lfStrobe_t strobe;

  lf_ctrl #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ADDR_W(ADDR_W),
    .TRCD  (TRCD),
    .TCAS  (TCAS),
    .TRP   (TRP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqLine (reqLine),
    .reqAck  (reqAck),
    .done    (done),
    .rasN    (dramRasN),
    .casN    (dramCasN),
    .weN     (dramWeN),
    .dramAddr(dramAddr),
    .strobe  (strobe)
  );

  lf_datapath #(
    .MEM_W(MEM_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wbLine   (wbLine),
    .wbPar    (wbPar),
    .dramDqIn (dramDqIn),
    .dramParIn(dramParIn),
    .fillValid(fillValid),
    .fillIdx  (fillIdx),
    .fillWord (fillWord),
    .fillPar  (fillPar),
    .dqOut    (dramDqOut),
    .parOut   (dramParOut),
    .dqOe     (dramDqOe)
  );

  // R8
  done_with_last_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillIdx) |-> done);

  // R7
  we_drives_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && !dramWeN) |-> dramDqOe);

endmodule

// File: tb/line_fill_ctrl_tb.sv
`timescale 1ns/1ps
module line_fill_ctrl_tb;

  localparam int ROW_W = 9;
  localparam int COL_W = 9;
  localparam int TRCD  = 2;
  localparam int TCAS  = 2;
  localparam int TRP   = 2;
  localparam int ACK_SPACING = TRCD + 4*TCAS + 3 + TRP + 1;

  typedef struct packed {
    logic        wr;
    logic [15:0] line;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h0000, 8'h00},
    '{1'b0, 16'hFFFF, 8'h00},
    '{1'b1, 16'h1234, 8'h11},
    '{1'b0, 16'h1234, 8'h00},
    '{1'b1, 16'h01FF, 8'hA7},
    '{1'b0, 16'h01FF, 8'h00}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [15:0]  reqLine = '0;
  logic [255:0] wbLine = '0;
  logic [7:0]   wbPar = '0;
  logic         reqAck, done, fillValid, fillIdx;
  logic [127:0] fillWord;
  logic [3:0]   fillPar;
  logic         dramRasN, dramCasN, dramWeN, dramDqOe;
  logic [8:0]   dramAddr;
  logic [63:0]  dramDqOut;
  logic [1:0]   dramParOut;
  logic [63:0]  dramDqIn = '0;
  logic [1:0]   dramParIn = '0;

  always #4 clk = ~clk;

  line_fill_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLine(reqLine), .wbLine(wbLine), .wbPar(wbPar), .reqAck(reqAck),
    .done(done), .fillValid(fillValid), .fillIdx(fillIdx), .fillWord(fillWord),
    .fillPar(fillPar), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .dramParOut(dramParOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn),
    .dramParIn(dramParIn)
  );

  int checks = 0;
  int failures = 0;
  int cycle = 0;

  // ---------------- DRAM model and monitor ----------------
  logic [65:0] wmem [int];
  logic        prevRas = 1'b1, prevCas = 1'b1;
  logic [8:0]  rowLat = '0;
  int rasLowCnt = 0, rasHighRun = 0, gapLog = 0;
  int casLowCnt = 0, casHighCnt = 0;
  int beatsSeen = 0, rcdSeen = 0, casLenBad = 0, casGapBad = 0, casOutRas = 0;
  int weBad = 0, oeBad = 0, ackCnt = 0, doneCnt = 0, doneRasBad = 0;
  int fillCnt = 0, doneWithLast = 0, lastAckCycle = 0, ackDelta = 0;
  logic [8:0]   colLog [4];
  logic [127:0] fillWordLog [2];
  logic [3:0]   fillParLog [2];
  logic         expWrite = 1'b0;

  function automatic logic [65:0] patWord(input logic [8:0] r, input logic [8:0] c);
    logic [15:0] r16 = {7'd0, r};
    logic [15:0] c16 = {7'd0, c};
    return {r[0] ^ c[1], c[0], 16'hA5C3 ^ r16, c16, r16 ^ 16'h003C, c16 ^ 16'hF00F};
  endfunction

  function automatic logic [65:0] memRd(input logic [8:0] r, input logic [8:0] c);
    int k = int'(r) * 512 + int'(c);
    if (wmem.exists(k)) return wmem[k];
    return patWord(r, c);
  endfunction

  always @(negedge clk) begin
    cycle++;
    if (!rstN) begin
      prevRas = 1'b1;
      prevCas = 1'b1;
    end else begin
      if (!dramRasN) begin
        if (prevRas) begin
          rowLat = dramAddr;
          rasLowCnt = 1;
          gapLog = rasHighRun;
        end else rasLowCnt++;
        rasHighRun = 0;
      end else rasHighRun++;
      if (!dramCasN) begin
        if (prevCas) begin
          if (dramRasN) casOutRas++;
          if (beatsSeen == 0) rcdSeen = rasLowCnt - 1;
          else if (casHighCnt != 1) casGapBad++;
          if (beatsSeen < 4) colLog[beatsSeen] = dramAddr;
          beatsSeen++;
          casLowCnt = 0;
          if (!dramWeN)
            wmem[int'(rowLat) * 512 + int'(dramAddr)] = {dramParOut, dramDqOut};
        end
        casLowCnt++;
        if (dramWeN == expWrite) weBad++;
        if (!dramWeN && !dramDqOe) oeBad++;
        if (dramWeN) {dramParIn, dramDqIn} = memRd(rowLat, dramAddr);
      end else begin
        if (!prevCas && casLowCnt != TCAS) casLenBad++;
        casHighCnt = prevCas ? casHighCnt + 1 : 1;
      end
      if (reqAck) begin
        ackCnt++;
        ackDelta = cycle - lastAckCycle;
        lastAckCycle = cycle;
      end
      if (done) begin
        doneCnt++;
        if (!dramRasN) doneRasBad++;
      end
      if (fillValid) begin
        fillWordLog[fillIdx] = fillWord;
        fillParLog[fillIdx] = fillPar;
        fillCnt++;
        if (fillIdx && done) doneWithLast++;
      end
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  // ---------------- reporting ----------------
  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycle > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycle);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLogs();
    beatsSeen = 0; rcdSeen = 0; casLenBad = 0; casGapBad = 0; casOutRas = 0;
    weBad = 0; oeBad = 0; ackCnt = 0; doneCnt = 0; doneRasBad = 0;
    fillCnt = 0; doneWithLast = 0;
  endtask

  function automatic logic [255:0] genLine(input logic [7:0] s);
    logic [255:0] v;
    for (int i = 0; i < 8; i++)
      v[32*i +: 32] = {s, 8'(i), ~s, 8'(i) ^ s};
    return v;
  endfunction

  task automatic waitDone(input int n);
    int guard = 0;
    while (doneCnt < n && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic runXfer(input logic wr, input logic [15:0] line, input logic [7:0] seed);
    logic [8:0]   row = line[15:7];
    logic [6:0]   hi = line[6:0];
    logic [255:0] wl = genLine(seed);
    logic [7:0]   wp = seed ^ 8'h5A;
    logic [127:0] expW [2];
    logic [3:0]   expP [2];
    for (int w = 0; w < 2; w++) begin
      logic [65:0] lo = memRd(row, {hi, 2'(2*w)});
      logic [65:0] up = memRd(row, {hi, 2'(2*w+1)});
      expW[w] = {up[63:0], lo[63:0]};
      expP[w] = {up[65:64], lo[65:64]};
    end
    @(negedge clk);
    clearLogs();
    expWrite = wr;
    reqValid = 1'b1; reqWrite = wr; reqLine = line; wbLine = wl; wbPar = wp;
    @(negedge clk);
    reqValid = 1'b0;
    wbLine = '0; wbPar = '0;
    waitDone(1);
    check(ackCnt == 1, "R2 ack count", 256'(ackCnt), 256'd1);
    check(rowLat == row, "R3 row address", 256'(rowLat), 256'(row));
    check(rcdSeen == TRCD, "R3 row-to-column delay", 256'(rcdSeen), 256'(TRCD));
    check(beatsSeen == 4 && casOutRas == 0, "R4 beat count", 256'(beatsSeen), 256'd4);
    check(casLenBad == 0 && casGapBad == 0, "R4 strobe widths",
          256'(casLenBad + casGapBad), 256'd0);
    for (int b = 0; b < 4; b++)
      check(colLog[b] == {hi, 2'(b)}, "R4 column order", 256'(colLog[b]), 256'({hi, 2'(b)}));
    check(weBad == 0 && oeBad == 0, "R7 write enable and drive", 256'(weBad + oeBad), 256'd0);
    check(doneCnt == 1 && doneRasBad == 0, "R8 done pulse", 256'(doneCnt), 256'd1);
    if (wr) begin
      for (int b = 0; b < 4; b++) begin
        logic [65:0] got = memRd(row, {hi, 2'(b)});
        check(got[63:0] == wl[64*b +: 64], "R7 written beat", 256'(got[63:0]), 256'(wl[64*b +: 64]));
        check(got[65:64] == wp[2*b +: 2], "R6 written parity", 256'(got[65:64]), 256'(wp[2*b +: 2]));
      end
      check(fillCnt == 0, "R5 no fill on write", 256'(fillCnt), 256'd0);
    end else begin
      check(fillCnt == 2, "R5 fill count", 256'(fillCnt), 256'd2);
      for (int w = 0; w < 2; w++) begin
        check(fillWordLog[w] == expW[w], "R5 packed word", 256'(fillWordLog[w]), 256'(expW[w]));
        check(fillParLog[w] == expP[w], "R6 fill parity", 256'(fillParLog[w]), 256'(expP[w]));
      end
      check(doneWithLast == 1, "R8 done with last word", 256'(doneWithLast), 256'd1);
    end
  endtask

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    check(dramRasN && dramCasN && dramWeN, "R1 strobes in reset",
          256'({dramRasN, dramCasN, dramWeN}), 256'h7);
    check(!dramDqOe && !reqAck && !done && !fillValid, "R1 outputs in reset",
          256'({dramDqOe, reqAck, done, fillValid}), 256'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 6; i++)
      runXfer(VECS[i].wr, VECS[i].line, VECS[i].seed);

    // R2 request during a transfer is ignored
    @(negedge clk);
    clearLogs();
    expWrite = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b0; reqLine = 16'h0A05;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqLine = 16'h7777;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(1);
    check(ackCnt == 1, "R2 busy request ignored", 256'(ackCnt), 256'd1);
    check(weBad == 0 && beatsSeen == 4, "R2 no write from ignored request",
          256'(weBad), 256'd0);
    repeat (20) @(negedge clk);
    check(ackCnt == 1 && doneCnt == 1, "R2 no later transfer", 256'(ackCnt), 256'd1);

    // R9 back-to-back reads with request held
    clearLogs();
    expWrite = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b0; reqLine = 16'h3C3C;
    begin
      int guard = 0;
      while (ackCnt < 2 && guard < 100) begin
        @(negedge clk);
        guard++;
      end
    end
    reqValid = 1'b0;
    check(ackDelta == ACK_SPACING, "R9 acknowledge spacing", 256'(ackDelta), 256'(ACK_SPACING));
    waitDone(2);
    check(gapLog == 3, "R9 row precharge gap", 256'(gapLog), 256'd3);
    check(ackCnt == 2 && doneCnt == 2 && fillCnt == 4, "R9 two transfers",
          256'({ackCnt[7:0], doneCnt[7:0], fillCnt[7:0]}), 256'h020204);
    check(doneWithLast == 2, "R8 done with last word back-to-back", 256'(doneWithLast), 256'd2);

    // R1 reset in the middle of a write
    clearLogs();
    expWrite = 1'b1;
    reqValid = 1'b1; reqWrite = 1'b1; reqLine = 16'h0101; wbLine = genLine(8'h33);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(dramRasN && dramCasN && dramWeN && !dramDqOe, "R1 mid-transfer reset",
          256'({dramRasN, dramCasN, dramWeN, dramDqOe}), 256'hE);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    finishRun();
  end

endmodule